// File: doc/BRIEF.md
# Pseudo-Ternary Basic-Access Frame Encoder

This block builds one 48-bit basic-access line frame at a time and turns it into a stream of pseudo-ternary symbols, one symbol per clock. Each symbol is a positive mark, a negative mark or a space. The frame carries two octets each of B1 and B2 data, four D-channel bits, four echo bits that return the D bits last received from the far end, and an activation bit. The block inserts the framing bit and the two balancing bits itself.

Mark polarity normally alternates. The block breaks that rule on purpose in two places so that a receiver can find the frame boundary. The first break is at the framing bit. The second is at the first mark after the frame-head balancing bit. If every data bit after that balancing bit is a one, the second break lands on the auxiliary framing bit, which is always a zero. Each balancing bit is set from a one-bit parity of the marks sent since the previous balancing bit, so the line carries no net DC.

All frame inputs are captured together, on the clock edge at which the framing bit is encoded. The caller can then change the inputs for the next frame while the current frame goes out.

Top module: `pt_frame_enc`

## Requirements
- R1: The frame has 16+4*OCT_W slots, which is 48 at the default, sent in this fixed order: framing 0, head balance 1, B1 octet 2-9, echo 10, D 11, activation 12, auxiliary framing 13, N 14, B2 octet 15-22, echo 23, D 24, multiframe 25, B1 octet 26-33, echo 34, D 35, S 36, B2 octet 37-44, echo 45, D 46, tail balance 47. `frame_sync_o` is high exactly while `sym_o` carries slot 0, so it recurs every 48 cycles.
- R2: `sym_o` is 2'b00 for a space, 2'b01 for a positive mark and 2'b10 for a negative mark. A binary 0 is sent as a mark and a binary 1 as a space. Each slot's symbol appears on `sym_o` one clock after that slot is encoded.
- R3: `load_o` is high during the cycle in which slot 0 is encoded. All frame inputs are captured on that rising edge. Input changes at any other time have no effect on the frame being sent. `load_o` is high as soon as reset is released.
- R4: While `rst_ni` is low, `sym_o` is a space, `frame_sync_o` is low and `load_o` is high. The polarity memory resets so that the first framing mark after reset is positive.
- R5: The framing bit is a mark with the same polarity as the mark before it. In steady operation this makes it always a positive mark.
- R6: A balancing bit (slot 1 or slot 47) is a mark when an odd number of marks has been sent since the previous balancing bit, and a space when that number is even. The count then restarts. Balancing marks follow normal alternation, so slot 1 is always a negative mark, and the marks in slots 2-47 always total an even number.
- R7: The first mark after slot 1 repeats the polarity of the slot-1 mark. This mark is a violation, and it falls no later than slot 13.
- R8: Every mark other than the framing mark and the R7 mark has the opposite polarity to the mark before it.
- R9: Echo slot k carries `echo_i[k]` and D slot k carries `d_i[k]` (k = 0..3, in frame order). The activation slot carries `act_i`. The auxiliary framing, N, multiframe and S slots carry binary 0.
- R10: The first B1 octet is `b1_i[7:0]` and the second is `b1_i[15:8]`, each sent least significant bit first. B2 uses `b2_i` in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock, one slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| b1_i | input | 2*OCT_W | Two B1 octets for the next frame |
| b2_i | input | 2*OCT_W | Two B2 octets for the next frame |
| d_i | input | 4 | D-channel bits for the next frame |
| echo_i | input | 4 | Received D bits to be echoed |
| act_i | input | 1 | Activation bit value |
| load_o | output | 1 | Inputs are captured at this cycle's rising edge |
| sym_o | output | 2 | Line symbol: 00 space, 01 positive, 10 negative |
| frame_sync_o | output | 1 | High while sym_o carries the framing bit |

## Verification
The bench builds the block with its default OCT_W of 8, which gives the standard 48-slot frame. With this frame size, every position at which the R7 violation can land (B1 bits, echo, D, activation, or the forced zero in slot 13) can be chosen through the data alone. The stimulus table places that violation at slots 2, 9, 10, 11, 12 and 13 in turn. For each frame the bench decodes the symbols, checks the balance across both balancing bits, and repeats polarity tracking across frame borders and across a reset taken in mid-frame.

// File: rtl/pt_enc_pkg.sv
package pt_enc_pkg;

    // number of D and echo slots in one frame
    localparam int NSUB = 4;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'b00,
        SYM_POS   = 2'b01,
        SYM_NEG   = 2'b10
    } sym_e;

    typedef enum logic [3:0] {
        SK_FRAME,
        SK_BAL_HEAD,
        SK_BAL_TAIL,
        SK_B1,
        SK_B2,
        SK_DCH,
        SK_ECHO,
        SK_ACT,
        SK_AUXF,
        SK_NBIT,
        SK_MULTI,
        SK_SCH
    } slot_kind_e;

endpackage

// File: rtl/pt_slot_seq.sv
module pt_slot_seq #(
    parameter int FRAME_LEN = 48,
    parameter int SLOT_W    = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic [SLOT_W-1:0] slot_o,
    output logic              load_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.slot == LAST_SLOT) begin
            seq_d.slot = '0;
        end else begin
            seq_d.slot = seq_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign slot_o = seq_q.slot;
    assign load_o = (seq_q.slot == '0);

endmodule

// File: rtl/pt_frame_mux.sv
module pt_frame_mux
    import pt_enc_pkg::*;
#(
    parameter int OCT_W  = 8,
    parameter int SLOT_W = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 load_i,
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic [2*OCT_W-1:0]   b1_i,
    input  logic [2*OCT_W-1:0]   b2_i,
    input  logic [NSUB-1:0]      d_i,
    input  logic [NSUB-1:0]      echo_i,
    input  logic                 act_i,
    output slot_kind_e           kind_o,
    output logic                 bit_o
);

    localparam int IDX_W = $clog2(2 * OCT_W);

    // slot positions, derived from the octet width
    localparam int P_B1A = 2;
    localparam int P_E0  = P_B1A + OCT_W;
    localparam int P_D0  = P_E0 + 1;
    localparam int P_A   = P_E0 + 2;
    localparam int P_FA  = P_E0 + 3;
    localparam int P_N   = P_E0 + 4;
    localparam int P_B2A = P_E0 + 5;
    localparam int P_E1  = P_B2A + OCT_W;
    localparam int P_D1  = P_E1 + 1;
    localparam int P_M   = P_E1 + 2;
    localparam int P_B1B = P_E1 + 3;
    localparam int P_E2  = P_B1B + OCT_W;
    localparam int P_D2  = P_E2 + 1;
    localparam int P_S   = P_E2 + 2;
    localparam int P_B2B = P_E2 + 3;
    localparam int P_E3  = P_B2B + OCT_W;
    localparam int P_D3  = P_E3 + 1;

    typedef struct packed {
        slot_kind_e       kind;
        logic [IDX_W-1:0] idx;
    } slot_info_t;

    typedef struct packed {
        logic [2*OCT_W-1:0] b1;
        logic [2*OCT_W-1:0] b2;
        logic [NSUB-1:0]    d;
        logic [NSUB-1:0]    echo;
        logic               act;
    } shadow_t;

    function automatic slot_info_t decode_slot(input logic [SLOT_W-1:0] s);
        slot_info_t r;
        int p;
        p      = int'(s);
        r.kind = SK_BAL_TAIL;
        r.idx  = '0;
        if (p == 0) begin
            r.kind = SK_FRAME;
        end else if (p == 1) begin
            r.kind = SK_BAL_HEAD;
        end else if (p < P_E0) begin
            r.kind = SK_B1;
            r.idx  = IDX_W'(p - P_B1A);
        end else if (p == P_E0) begin
            r.kind = SK_ECHO;
            r.idx  = IDX_W'(0);
        end else if (p == P_D0) begin
            r.kind = SK_DCH;
            r.idx  = IDX_W'(0);
        end else if (p == P_A) begin
            r.kind = SK_ACT;
        end else if (p == P_FA) begin
            r.kind = SK_AUXF;
        end else if (p == P_N) begin
            r.kind = SK_NBIT;
        end else if (p < P_E1) begin
            r.kind = SK_B2;
            r.idx  = IDX_W'(p - P_B2A);
        end else if (p == P_E1) begin
            r.kind = SK_ECHO;
            r.idx  = IDX_W'(1);
        end else if (p == P_D1) begin
            r.kind = SK_DCH;
            r.idx  = IDX_W'(1);
        end else if (p == P_M) begin
            r.kind = SK_MULTI;
        end else if (p < P_E2) begin
            r.kind = SK_B1;
            r.idx  = IDX_W'(p - P_B1B + OCT_W);
        end else if (p == P_E2) begin
            r.kind = SK_ECHO;
            r.idx  = IDX_W'(2);
        end else if (p == P_D2) begin
            r.kind = SK_DCH;
            r.idx  = IDX_W'(2);
        end else if (p == P_S) begin
            r.kind = SK_SCH;
        end else if (p < P_E3) begin
            r.kind = SK_B2;
            r.idx  = IDX_W'(p - P_B2B + OCT_W);
        end else if (p == P_E3) begin
            r.kind = SK_ECHO;
            r.idx  = IDX_W'(3);
        end else if (p == P_D3) begin
            r.kind = SK_DCH;
            r.idx  = IDX_W'(3);
        end
        return r;
    endfunction

    shadow_t    sh_d, sh_q;
    slot_info_t info;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.b1   = b1_i;
            sh_d.b2   = b2_i;
            sh_d.d    = d_i;
            sh_d.echo = echo_i;
            sh_d.act  = act_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    always_comb begin
        info = decode_slot(slot_i);
        case (info.kind)
            SK_B1:   bit_o = sh_q.b1[info.idx];
            SK_B2:   bit_o = sh_q.b2[info.idx];
            SK_DCH:  bit_o = sh_q.d[info.idx[1:0]];
            SK_ECHO: bit_o = sh_q.echo[info.idx[1:0]];
            SK_ACT:  bit_o = sh_q.act;
            SK_FRAME, SK_AUXF, SK_NBIT, SK_MULTI, SK_SCH: bit_o = 1'b0;
            default: bit_o = 1'b1;
        endcase
    end

    assign kind_o = info.kind;

endmodule

// File: rtl/pt_line_coder.sv
module pt_line_coder
    import pt_enc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  slot_kind_e kind_i,
    input  logic       bit_i,
    output logic [1:0] sym_o,
    output logic       sync_o
);

    typedef struct packed {
        sym_e sym;
        logic sync;
        logic last_pos;  // polarity of the most recent mark
        logic par;       // odd count of marks since the last balancing bit
        logic pend;      // next data mark must repeat the polarity
    } coder_t;

    coder_t cq_d, cq_q;
    logic   mark;
    logic   pos;

    always_comb begin
        cq_d = cq_q;
        mark = 1'b0;
        pos  = cq_q.last_pos;
        case (kind_i)
            SK_FRAME: begin
                mark = 1'b1;
                pos  = cq_q.last_pos;
            end
            SK_BAL_HEAD: begin
                mark      = cq_q.par;
                pos       = !cq_q.last_pos;
                cq_d.pend = 1'b1;
            end
            SK_BAL_TAIL: begin
                mark = cq_q.par;
                pos  = !cq_q.last_pos;
            end
            default: begin
                mark = !bit_i;
                pos  = cq_q.pend ? cq_q.last_pos : !cq_q.last_pos;
                if (mark) begin
                    cq_d.pend = 1'b0;
                end
            end
        endcase

        if (kind_i == SK_BAL_HEAD || kind_i == SK_BAL_TAIL) begin
            cq_d.par = 1'b0;
        end else begin
            cq_d.par = cq_q.par ^ mark;
        end

        if (mark) begin
            cq_d.last_pos = pos;
            cq_d.sym      = pos ? SYM_POS : SYM_NEG;
        end else begin
            cq_d.sym = SYM_SPACE;
        end
        cq_d.sync = (kind_i == SK_FRAME);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cq_q <= '{sym: SYM_SPACE, sync: 1'b0, last_pos: 1'b1, par: 1'b0, pend: 1'b0};
        end else begin
            cq_q <= cq_d;
        end
    end

    assign sym_o  = cq_q.sym;
    assign sync_o = cq_q.sync;

endmodule

// File: rtl/pt_frame_enc.sv
module pt_frame_enc
    import pt_enc_pkg::*;
#(
    parameter int OCT_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [2*OCT_W-1:0] b1_i,
    input  logic [2*OCT_W-1:0] b2_i,
    input  logic [NSUB-1:0]    d_i,
    input  logic [NSUB-1:0]    echo_i,
    input  logic               act_i,
    output logic               load_o,
    output logic [1:0]         sym_o,
    output logic               frame_sync_o
);

    localparam int FRAME_LEN = 4 * OCT_W + 16;
    localparam int SLOT_W    = $clog2(FRAME_LEN);

    logic [SLOT_W-1:0] slot;
    logic              load;
    slot_kind_e        kind;
    logic              slot_bit;

    pt_slot_seq #(
        .FRAME_LEN (FRAME_LEN),
        .SLOT_W    (SLOT_W)
    ) seq_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .slot_o (slot),
        .load_o (load)
    );

    pt_frame_mux #(
        .OCT_W  (OCT_W),
        .SLOT_W (SLOT_W)
    ) mux_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .slot_i (slot),
        .b1_i   (b1_i),
        .b2_i   (b2_i),
        .d_i    (d_i),
        .echo_i (echo_i),
        .act_i  (act_i),
        .kind_o (kind),
        .bit_o  (slot_bit)
    );

    pt_line_coder coder_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .kind_i (kind),
        .bit_i  (slot_bit),
        .sym_o  (sym_o),
        .sync_o (frame_sync_o)
    );

    assign load_o = load;

endmodule

// File: rtl/pt_frame_enc_chk.sv
module pt_frame_enc_chk #(
    parameter int FRAME_LEN = 48
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       load_o,
    input logic [1:0] sym_o,
    input logic       frame_sync_o
);

    localparam int CW = $clog2(FRAME_LEN + 1);
    localparam logic [CW-1:0] C_ONE  = CW'(1);
    localparam logic [CW-1:0] C_TWO  = CW'(2);
    localparam logic [CW-1:0] C_LAST = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] C_LEN  = CW'(FRAME_LEN);

    logic          seen_q;
    logic [CW-1:0] cnt_q;
    logic          lastpos_q;
    logic          pend_q;
    logic          par_q;
    logic [CW-1:0] cur;
    logic          is_mark;
    logic          is_pos;

    assign cur     = frame_sync_o ? '0 : cnt_q;
    assign is_mark = (sym_o != 2'b00);
    assign is_pos  = (sym_o == 2'b01);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q    <= 1'b0;
            cnt_q     <= '0;
            lastpos_q <= 1'b1;
            pend_q    <= 1'b0;
            par_q     <= 1'b0;
        end else begin
            if (frame_sync_o) begin
                seen_q <= 1'b1;
                cnt_q  <= C_ONE;
            end else if (seen_q && cnt_q != C_LEN) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (is_mark) begin
                lastpos_q <= is_pos;
            end
            if (seen_q && cur == C_ONE) begin
                pend_q <= 1'b1;
                par_q  <= 1'b0;
            end else if (seen_q && cur >= C_TWO) begin
                if (is_mark) begin
                    pend_q <= 1'b0;
                end
                par_q <= par_q ^ is_mark;
            end
        end
    end

    // R5
    framing_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_sync_o |-> sym_o == 2'b01);

    // R6
    head_bal_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && cur == C_ONE) |-> sym_o == 2'b10);

    // R6
    tail_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && cur == C_LAST) |-> !(par_q ^ is_mark));

    // R7
    viol_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && is_mark && cur >= C_TWO && pend_q) |-> is_pos == lastpos_q);

    // R8
    alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && is_mark && cur >= C_TWO && !pend_q) |-> is_pos != lastpos_q);

    // R3
    load_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |=> frame_sync_o);

    // R1
    frame_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && frame_sync_o) |-> cnt_q == C_LEN);

endmodule

bind pt_frame_enc pt_frame_enc_chk #(
    .FRAME_LEN (FRAME_LEN)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_o       (load_o),
    .sym_o        (sym_o),
    .frame_sync_o (frame_sync_o)
);

// File: tb/pt_frame_enc_tb_top.sv
module pt_frame_enc_tb_top;

    localparam int NSLOT = 48;
    localparam int NV    = 7;

    // {b1[15:0], b2[15:0], d[3:0], echo[3:0], act, expected R7 violation slot[5:0]}
    localparam logic [46:0] VEC [NV] = '{
        {16'hFFFF, 16'hFFFF, 4'hF, 4'hF, 1'b1, 6'd13},
        {16'h0000, 16'h0000, 4'h0, 4'h0, 1'b0, 6'd2},
        {16'h127F, 16'h5555, 4'h3, 4'hC, 1'b1, 6'd9},
        {16'h00FF, 16'h0F0F, 4'hF, 4'hE, 1'b1, 6'd10},
        {16'hFFFF, 16'h1234, 4'hE, 4'hF, 1'b0, 6'd11},
        {16'hFFFF, 16'hFFFF, 4'hF, 4'hF, 1'b0, 6'd12},
        {16'h3C5A, 16'h96E1, 4'hA, 4'h5, 1'b0, 6'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] b1 = '0;
    logic [15:0] b2 = '0;
    logic [3:0]  d = '0;
    logic [3:0]  echo = '0;
    logic        act = 1'b0;
    logic        load;
    logic [1:0]  sym;
    logic        fsync;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [1:0] got [NSLOT];
    logic       gsy [NSLOT];
    logic [1:0] exp_sym [NSLOT];
    logic       r_pos, r_par, r_pend, dec_pos;

    always #2 clk = ~clk;

    pt_frame_enc dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .b1_i         (b1),
        .b2_i         (b2),
        .d_i          (d),
        .echo_i       (echo),
        .act_i        (act),
        .load_o       (load),
        .sym_o        (sym),
        .frame_sync_o (fsync)
    );

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic drive(input logic [46:0] v);
        b1 = v[46:31]; b2 = v[30:15]; d = v[14:11]; echo = v[10:7]; act = v[6];
    endtask

    function automatic logic [NSLOT-1:0] frame_bits(input logic [46:0] v);
        logic [NSLOT-1:0] fb;
        fb = '1;
        fb[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            fb[2 + i]  = v[31 + i];
            fb[15 + i] = v[15 + i];
            fb[26 + i] = v[39 + i];
            fb[37 + i] = v[23 + i];
        end
        fb[10] = v[7];  fb[11] = v[11]; fb[12] = v[6]; fb[13] = 1'b0; fb[14] = 1'b0;
        fb[23] = v[8];  fb[24] = v[12]; fb[25] = 1'b0;
        fb[34] = v[9];  fb[35] = v[13]; fb[36] = 1'b0;
        fb[45] = v[10]; fb[46] = v[14];
        return fb;
    endfunction

    task automatic ref_encode(input logic [46:0] v);
        logic [NSLOT-1:0] fb;
        logic m, p;
        fb = frame_bits(v);
        for (int s = 0; s < NSLOT; s++) begin
            if (s == 0) begin
                m = 1'b1; p = r_pos; r_par = ~r_par;
            end else if (s == 1 || s == NSLOT - 1) begin
                m = r_par; p = ~r_pos; r_par = 1'b0;
                if (s == 1) r_pend = 1'b1;
            end else begin
                m = ~fb[s];
                p = r_pend ? r_pos : ~r_pos;
                if (m) r_pend = 1'b0;
                r_par = r_par ^ m;
            end
            if (m) r_pos = p;
            exp_sym[s] = m ? (p ? 2'b01 : 2'b10) : 2'b00;
        end
    endtask

    task automatic check_frame(input logic [46:0] v, input int tag);
        int bad;
        int ma, mb;
        logic [NSLOT-1:0] vio, vexp;
        logic ok;
        bad = -1;
        for (int k = NSLOT - 1; k >= 0; k--) if (got[k] !== exp_sym[k]) bad = k;
        chk(bad < 0, $sformatf("R2 R3 R10 frame %0d slot %0d got %b exp %b", tag,
            (bad < 0) ? 0 : bad, (bad < 0) ? 2'b00 : got[bad], (bad < 0) ? 2'b00 : exp_sym[bad]));
        chk(got[0] == 2'b01 && got[1] == 2'b10, $sformatf(
            "R5 R6 frame %0d F/L got %b %b exp 01 10", tag, got[0], got[1]));
        vio = '0;
        for (int k = 0; k < NSLOT; k++) begin
            if (got[k] != 2'b00) begin
                if ((got[k] == 2'b01) == dec_pos) vio[k] = 1'b1;
                dec_pos = (got[k] == 2'b01);
            end
        end
        vexp = '0; vexp[0] = 1'b1; vexp[v[5:0]] = 1'b1;
        chk(vio == vexp, $sformatf("R7 R8 frame %0d violations got %h exp %h", tag, vio, vexp));
        ma = 0; mb = 0;
        for (int k = 0; k < NSLOT; k++) if (got[k] != 2'b00) begin
            if (k < 2) ma++; else mb++;
        end
        chk(ma % 2 == 0 && mb % 2 == 0, $sformatf(
            "R6 frame %0d mark counts got %0d/%0d exp even/even", tag, ma, mb));
        ok = 1'b1;
        for (int j = 0; j < 4; j++) begin
            int es;
            es = 10 + 13 * j - ((j == 3) ? 4 : 0) - ((j == 2) ? 2 : 0) - ((j == 1) ? 0 : 0);
            if ((got[es] != 2'b00) != !v[7 + j]) ok = 1'b0;
        end
        chk(ok, $sformatf("R9 frame %0d echo slots got %b%b%b%b exp echo %b", tag,
            got[45], got[34], got[23], got[10], v[10:7]));
        ok = 1'b1;
        for (int k = 0; k < NSLOT; k++) if (gsy[k] !== (k == 0)) ok = 1'b0;
        chk(ok, $sformatf("R1 frame %0d sync got %b at slot0 exp 1 and 0 elsewhere", tag, gsy[0]));
    endtask

    task automatic run_frame(input logic [46:0] v, input int tag);
        drive(v);
        ref_encode(v);
        for (int k = 0; k < NSLOT; k++) begin
            @(negedge clk);
            got[k] = sym;
            gsy[k] = fsync;
            if (k == 0) drive(~v);  // R3: late changes must not reach this frame
        end
        check_frame(v, tag);
    endtask

    task automatic reset_ref();
        r_pos = 1'b1; r_par = 1'b0; r_pend = 1'b0; dec_pos = 1'b1;
    endtask

    initial begin
        reset_ref();
        repeat (3) @(negedge clk);
        // R4 reset state
        chk(sym == 2'b00, $sformatf("R4 sym in reset got %b exp 00", sym));
        chk(fsync == 1'b0, $sformatf("R4 sync in reset got %b exp 0", fsync));
        chk(load == 1'b1, $sformatf("R3 load in reset got %b exp 1", load));
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) run_frame(VEC[v], v);
        // mid-frame reset
        drive(VEC[2]);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(sym == 2'b00, $sformatf("R4 sym after mid reset got %b exp 00", sym));
        chk(fsync == 1'b0, $sformatf("R4 sync after mid reset got %b exp 0", fsync));
        chk(load == 1'b1, $sformatf("R3 load after mid reset got %b exp 1", load));
        @(negedge clk);
        rst_n = 1'b1;
        reset_ref();
        run_frame(VEC[6], 100);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired got running exp finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule